// File: doc/BRIEF.md
# PLL Bring-Up Sequencer

This block brings a general-purpose PLL out of reset in hardware, so firmware does not have to time each control write. After a start request it raises the PLL control lines one at a time. It waits a fixed number of microseconds between steps, then watches the PLL's lock indication for a bounded window. The outcome is a sticky done flag or a sticky error flag. A prescaler divides the system clock into a microsecond tick. The number of clock cycles per microsecond is a parameter.

The block supports two orderings, chosen when a sequence starts. The general ordering puts the PLL into standby, releases reset, and enables the output branch. It then waits for lock. The CPU ordering releases bypass, releases reset, and waits for lock. It drives output control only when lock has been seen. An optional enable for the PLL's internal state machine can be requested at start. That enable is driven one cycle ahead of the first step.

Top module: `pll_bringup_seq`

## Requirements
- R1: A synchronous active-high `rst` returns the sequencer to idle. All control outputs, `done_o` and `err_o` read 0 in the cycle after the reset edge.
- R2: A start is accepted only when no sequence is running. The accepting edge sets `fsm_en_o` to `fsm_en_cfg_i`. The first control step follows one edge later, so `fsm_en_o` is already valid for one cycle when that step appears.
- R3: With `mode_i` = 0 (general ordering), `standby_o` rises first. `rst_rel_o` rises GP_STBY_US*CYC_PER_US+1 cycles after it.
- R4: In the general ordering, `branch_en_o` rises GP_RST_US*CYC_PER_US+1 cycles after `rst_rel_o`.
- R5: With `mode_i` = 1 (CPU ordering), `bypass_rel_o` rises first and `rst_rel_o` rises CPU_BYP_US*CYC_PER_US+1 cycles after it. `standby_o` and `branch_en_o` stay 0 in this ordering.
- R6: The lock window opens at the edge of the last step. That step is `branch_en_o` in the general ordering and `rst_rel_o` in the CPU ordering. `lock_i` is sampled in each of the next LOCK_US*CYC_PER_US+1 cycles. If lock is seen k cycles after the window opens, `done_o` rises k+1 cycles after it opens. Otherwise `err_o` rises LOCK_US*CYC_PER_US+1 cycles after it opens. If lock arrives in the last cycle of the window, the result is success.
- R7: In the CPU ordering, `outctl_o` rises on the same edge as `done_o`. On a timeout, `outctl_o` stays 0. `outctl_o` never rises in the general ordering.
- R8: `done_o` and `err_o` are never high together. Each stays high until the edge that accepts the next start, and that edge clears it.
- R9: A start pulse during a running sequence has no effect. This holds even when `mode_i` is different at the time of the pulse: the step timing, the ordering and the outcome stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, one cycle |
| mode_i | input | 1 | Ordering select at start: 0 general, 1 CPU |
| fsm_en_cfg_i | input | 1 | Request the PLL internal state machine enable |
| lock_i | input | 1 | Lock indication from the PLL |
| fsm_en_o | output | 1 | PLL internal state machine enable |
| standby_o | output | 1 | Standby operating mode request |
| bypass_rel_o | output | 1 | Bypass release |
| rst_rel_o | output | 1 | PLL reset release |
| branch_en_o | output | 1 | Output branch enable |
| outctl_o | output | 1 | Output control enable |
| done_o | output | 1 | Sequence completed with lock (sticky) |
| err_o | output | 1 | Lock wait timed out (sticky) |

## Verification
Two events can fall in the same cycle: lock arriving, and expiry of the lock-wait interval. The bench's PLL model raises lock a programmed number of cycles after the last step. A run with the delay set to exactly the window length puts lock on the expiry cycle, and the scoreboard expects success. The same run with a delay one cycle longer expects an error, with the error flag at the window boundary. Start pulses with the opposite ordering are also injected mid-sequence, and the bench confirms that interval lengths and the ordering are unchanged.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_GP_STBY,
        ST_GP_RSTW,
        ST_CPU_BYP,
        ST_LOCK_WAIT
    } seq_state_e;

    typedef enum logic {
        SEQ_GP  = 1'b0,
        SEQ_CPU = 1'b1
    } seq_mode_e;

    typedef struct packed {
        logic fsm_en;
        logic standby;
        logic bypass_rel;
        logic rst_rel;
        logic branch_en;
        logic outctl;
    } pll_ctl_t;

    function automatic int unsigned max_of3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pll_us_tick.sv
module pll_us_tick #(
    parameter int unsigned CYC_PER_US = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic tick_o
);
    localparam int unsigned PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [PW-1:0] LAST = PW'(CYC_PER_US - 1);

    logic [PW-1:0] pre_q;

    assign tick_o = (pre_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr_i || tick_o) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/pll_us_timer.sv
module pll_us_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    assign expired_o = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (tick_i && !expired_o) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
    import pll_seq_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 125,
    parameter int unsigned GP_STBY_US = 1,
    parameter int unsigned GP_RST_US  = 10,
    parameter int unsigned CPU_BYP_US = 5,
    parameter int unsigned LOCK_US    = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic mode_i,
    input  logic fsm_en_cfg_i,
    input  logic lock_i,
    output logic fsm_en_o,
    output logic standby_o,
    output logic bypass_rel_o,
    output logic rst_rel_o,
    output logic branch_en_o,
    output logic outctl_o,
    output logic done_o,
    output logic err_o
);
    localparam int unsigned MAX_US = max_of3(max_of3(GP_STBY_US, GP_RST_US, CPU_BYP_US), LOCK_US, 1);
    localparam int unsigned CNT_W  = $clog2(MAX_US + 1);

    seq_state_e       st_q;
    seq_mode_e        mode_q;
    pll_ctl_t         ctl_q;
    logic             done_q;
    logic             err_q;

    logic             tick;
    logic             expired;
    logic             load;
    logic [CNT_W-1:0] load_val;

    // Interval selection: each wait state is armed on the edge that leaves the prior step
    always_comb begin
        load     = 1'b0;
        load_val = '0;
        unique case (st_q)
            ST_ARM: begin
                load     = 1'b1;
                load_val = (mode_q == SEQ_CPU) ? CNT_W'(CPU_BYP_US) : CNT_W'(GP_STBY_US);
            end
            ST_GP_STBY: begin
                load     = expired;
                load_val = CNT_W'(GP_RST_US);
            end
            ST_GP_RSTW, ST_CPU_BYP: begin
                load     = expired;
                load_val = CNT_W'(LOCK_US);
            end
            default: ;
        endcase
    end

    pll_us_tick #(.CYC_PER_US(CYC_PER_US)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (load),
        .tick_o (tick)
    );

    pll_us_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load),
        .load_val_i (load_val),
        .tick_i     (tick),
        .expired_o  (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            mode_q <= SEQ_GP;
            ctl_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        ctl_q        <= '0;
                        ctl_q.fsm_en <= fsm_en_cfg_i;
                        done_q       <= 1'b0;
                        err_q        <= 1'b0;
                        mode_q       <= seq_mode_e'(mode_i);
                        st_q         <= ST_ARM;
                    end
                end
                ST_ARM: begin
                    if (mode_q == SEQ_CPU) begin
                        ctl_q.bypass_rel <= 1'b1;
                        st_q             <= ST_CPU_BYP;
                    end else begin
                        ctl_q.standby <= 1'b1;
                        st_q          <= ST_GP_STBY;
                    end
                end
                ST_GP_STBY: begin
                    if (expired) begin
                        ctl_q.rst_rel <= 1'b1;
                        st_q          <= ST_GP_RSTW;
                    end
                end
                ST_GP_RSTW: begin
                    if (expired) begin
                        ctl_q.branch_en <= 1'b1;
                        st_q            <= ST_LOCK_WAIT;
                    end
                end
                ST_CPU_BYP: begin
                    if (expired) begin
                        ctl_q.rst_rel <= 1'b1;
                        st_q          <= ST_LOCK_WAIT;
                    end
                end
                ST_LOCK_WAIT: begin
                    // lock takes precedence over a window closing in the same cycle
                    if (lock_i) begin
                        done_q <= 1'b1;
                        if (mode_q == SEQ_CPU) begin
                            ctl_q.outctl <= 1'b1;
                        end
                        st_q <= ST_IDLE;
                    end else if (expired) begin
                        err_q <= 1'b1;
                        st_q  <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign fsm_en_o     = ctl_q.fsm_en;
    assign standby_o    = ctl_q.standby;
    assign bypass_rel_o = ctl_q.bypass_rel;
    assign rst_rel_o    = ctl_q.rst_rel;
    assign branch_en_o  = ctl_q.branch_en;
    assign outctl_o     = ctl_q.outctl;
    assign done_o       = done_q;
    assign err_o        = err_q;
endmodule

// File: rtl/pll_bringup_seq_chk.sv
module pll_bringup_seq_chk (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic lock_i,
    input logic fsm_en_o,
    input logic standby_o,
    input logic bypass_rel_o,
    input logic rst_rel_o,
    input logic branch_en_o,
    input logic outctl_o,
    input logic done_o,
    input logic err_o
);
    logic rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
    end

    always @(posedge clk) begin
        if (rst_seen_q === 1'b1) begin
            AST_RESET_CLEAR: assert ({fsm_en_o, standby_o, bypass_rel_o, rst_rel_o,
                                      branch_en_o, outctl_o, done_o, err_o} == 8'b0); // R1
        end
    end

    AST_RST_AFTER_FIRST: assert property (@(posedge clk) disable iff (rst)
        rst_rel_o |-> (standby_o || bypass_rel_o)); // R3
    AST_BRANCH_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
        branch_en_o |-> rst_rel_o); // R4
    AST_ORDER_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(standby_o && bypass_rel_o)); // R5
    AST_OUTCTL_ON_LOCK: assert property (@(posedge clk) disable iff (rst)
        $rose(outctl_o) |-> ($past(lock_i) && $rose(done_o))); // R7
    AST_OUTCTL_NOT_ERR: assert property (@(posedge clk) disable iff (rst)
        outctl_o |-> !err_o); // R7
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_o, err_o})); // R8
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o); // R8
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (err_o && !start_i) |=> err_o); // R8
endmodule

bind pll_bringup_seq pll_bringup_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .lock_i       (lock_i),
    .fsm_en_o     (fsm_en_o),
    .standby_o    (standby_o),
    .bypass_rel_o (bypass_rel_o),
    .rst_rel_o    (rst_rel_o),
    .branch_en_o  (branch_en_o),
    .outctl_o     (outctl_o),
    .done_o       (done_o),
    .err_o        (err_o)
);

// File: tb/pll_bringup_seq_tb.sv
module pll_bringup_seq_tb;
    localparam int CYC  = 4;
    localparam int STBY = 1;
    localparam int RSTW = 10;
    localparam int BYP  = 5;
    localparam int LCK  = 100;
    localparam int WIN  = LCK * CYC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic mode_i = 1'b0;
    logic fsm_en_cfg_i = 1'b0;
    logic lock_i;
    logic fsm_en_o, standby_o, bypass_rel_o, rst_rel_o, branch_en_o, outctl_o, done_o, err_o;

    always #4 clk = ~clk;

    pll_bringup_seq #(
        .CYC_PER_US(CYC), .GP_STBY_US(STBY), .GP_RST_US(RSTW),
        .CPU_BYP_US(BYP), .LOCK_US(LCK)
    ) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .fsm_en_cfg_i(fsm_en_cfg_i), .lock_i(lock_i),
        .fsm_en_o(fsm_en_o), .standby_o(standby_o), .bypass_rel_o(bypass_rel_o),
        .rst_rel_o(rst_rel_o), .branch_en_o(branch_en_o), .outctl_o(outctl_o),
        .done_o(done_o), .err_o(err_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // PLL model: lock rises lock_dly cycles after the last step of the active ordering
    bit cur_cpu = 0;
    int lock_dly = 0;
    int lcnt = 0;
    logic armed;
    assign armed  = cur_cpu ? rst_rel_o : branch_en_o;
    assign lock_i = armed && (lcnt >= lock_dly);
    always @(posedge clk) lcnt <= armed ? lcnt + 1 : 0;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        bit cpu;
        bit fen;
        bit ok;
        int dly;
    } exp_t;
    exp_t sb_q[$];

    // Monitor
    logic p_stby = 0, p_byp = 0, p_rst = 0, p_br = 0, p_fin = 0, p_fsm = 0;
    logic fsm_at_step = 0;
    int t_stby = 0, t_byp = 0, t_rst = 0, t_br = 0;

    task automatic judge(input int t_fin);
        exp_t e;
        int t_last;
        if (sb_q.size() == 0) begin
            chk(0, "R6 unexpected finish", 1, 0);
            return;
        end
        e = sb_q.pop_front();
        chk(done_o == e.ok && err_o == !e.ok, "R6 outcome", done_o, e.ok);
        chk(fsm_at_step == e.fen, "R2 fsm enable before first step", fsm_at_step, e.fen);
        if (e.cpu) begin
            chk(t_rst - t_byp == BYP * CYC + 1, "R5 bypass-to-reset interval", t_rst - t_byp, BYP * CYC + 1);
            chk(!standby_o && !branch_en_o, "R5 general-only outputs idle", {standby_o, branch_en_o}, 0);
            chk(outctl_o == e.ok, "R7 output control", outctl_o, e.ok);
            t_last = t_rst;
        end else begin
            chk(t_rst - t_stby == STBY * CYC + 1, "R3 standby-to-reset interval", t_rst - t_stby, STBY * CYC + 1);
            chk(t_br - t_rst == RSTW * CYC + 1, "R4 reset-to-branch interval", t_br - t_rst, RSTW * CYC + 1);
            chk(!bypass_rel_o && !outctl_o, "R7 CPU-only outputs idle", {bypass_rel_o, outctl_o}, 0);
            t_last = t_br;
        end
        chk(t_fin - t_last == (e.ok ? e.dly : WIN) + 1, "R6 finish time",
            t_fin - t_last, (e.ok ? e.dly : WIN) + 1);
    endtask

    always @(negedge clk) begin
        if (standby_o && !p_stby) begin t_stby = cyc; fsm_at_step = p_fsm; end
        if (bypass_rel_o && !p_byp) begin t_byp = cyc; fsm_at_step = p_fsm; end
        if (rst_rel_o && !p_rst) t_rst = cyc;
        if (branch_en_o && !p_br) t_br = cyc;
        if ((done_o || err_o) && !p_fin) judge(cyc);
        p_stby = standby_o; p_byp = bypass_rel_o; p_rst = rst_rel_o;
        p_br = branch_en_o; p_fin = done_o || err_o; p_fsm = fsm_en_o;
    end

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    // Driver: pushes the expected result, then runs one sequence
    task automatic run_seq(input bit cpu, input bit fen, input int dly, input bit poke);
        exp_t e;
        bit exp_ok;
        exp_ok   = (dly <= WIN);
        e.cpu    = cpu; e.fen = fen; e.ok = exp_ok; e.dly = dly;
        sb_q.push_back(e);
        cur_cpu      = cpu;
        lock_dly     = dly;
        mode_i       = cpu;
        fsm_en_cfg_i = fen;
        pulse_start();
        chk(!done_o && !err_o, "R8 flags cleared on accepted start", {done_o, err_o}, 0);
        if (poke) begin
            repeat (15) @(negedge clk);
            mode_i       = !cpu;
            fsm_en_cfg_i = !fen;
            pulse_start();
            mode_i       = cpu;
            fsm_en_cfg_i = fen;
        end
        while (!(done_o || err_o)) @(negedge clk);
        repeat (12) @(negedge clk);
        chk(done_o == exp_ok && err_o == !exp_ok, "R8 flags held", {done_o, err_o}, {exp_ok, !exp_ok});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({fsm_en_o, standby_o, bypass_rel_o, rst_rel_o, branch_en_o, outctl_o, done_o, err_o} == 8'b0,
            "R1 reset state", {standby_o, rst_rel_o, done_o}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        run_seq(0, 1, 7, 0);        // general ordering, quick lock
        run_seq(0, 0, WIN, 0);      // lock on the last window cycle: success wins
        run_seq(0, 0, WIN + 1, 0);  // lock one cycle late: timeout
        run_seq(1, 1, 0, 0);        // CPU ordering, lock immediately
        run_seq(1, 0, 100000, 0);   // CPU ordering, never locks
        run_seq(1, 1, 30, 1);       // R9: mid-sequence start with other mode
        run_seq(0, 0, 50, 1);       // R9: mid-sequence start during reset wait

        // R1: reset in the middle of a sequence
        cur_cpu  = 0;
        lock_dly = 5;
        mode_i   = 0;
        pulse_start();
        repeat (8) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk({fsm_en_o, standby_o, bypass_rel_o, rst_rel_o, branch_en_o, outctl_o, done_o, err_o} == 8'b0,
            "R1 mid-sequence reset", {standby_o, rst_rel_o}, 0);
        repeat (60) @(negedge clk);
        chk(!standby_o && !rst_rel_o && !done_o, "R1 stays idle after reset", {standby_o, rst_rel_o, done_o}, 0);
        chk(sb_q.size() == 0, "R6 all expected results seen", sb_q.size(), 0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end
endmodule